// File: doc/BRIEF.md
# Instruction Boundary Checkpoint Monitor

This block sits beside a command-driven design under test and follows its instruction stream one command at a time. It sees a decode-match bit for each opcode. A match starts an instruction. The block then tracks the instruction until it completes. Each opcode completes by one of two rules: a fixed number of cycles after its start, or the first commit pulse that follows its start. Every completed instruction gets a running 1-based index.

When an instruction completes, a checkpoint policy decides whether a downstream state checker should compare architectural state at that point. There are four policies: every instruction, every P-th instruction, the indices held in a preloaded ascending list, or only while an external condition input is high. If the policy selects the instruction, the block raises a one-cycle compare request. The request carries the index and the opcode of the instruction that completed. The comparison itself happens outside this block.

The tracker is a three-state machine. TR_IDLE goes to TR_COUNT when a decode match selects a fixed-latency opcode, and goes to TR_AWAIT when the match selects a commit-finished opcode. TR_COUNT returns to TR_IDLE when its down-counter is zero (the finish cycle). TR_AWAIT returns to TR_IDLE in the first cycle in which commit is high. Every other case stays in the current state.

Top module: `insn_ckpt_monitor`

## Requirements
- R1: A synchronous reset clears the in-flight state, the completed-instruction count (so the next instruction to finish gets index 1), the list pointer, the overlap flag and the compare request.
- R2: In TR_IDLE, any set bit of `dec_match` starts an instruction in that cycle. When several bits are set, the lowest set bit gives the opcode.
- R3: An opcode whose `op_commit_mode` bit is 0 finishes n cycles after its start cycle. Here n is bits [j*4 +: 4] of `op_latency` for opcode j, and a field value of 0 acts as 1.
- R4: An opcode whose `op_commit_mode` bit is 1 finishes in the first cycle after its start cycle in which `commit` is high. A commit in the start cycle itself is ignored.
- R5: `cmp_req` is high for exactly the one cycle after a finish cycle, and only if the policy selects that instruction. At every finish, `cmp_index` and `cmp_opcode` take the 1-based index and the opcode of the finished instruction.
- R6: With `ckpt_mode` = 0, every finished instruction raises a compare.
- R7: With `ckpt_mode` = 1, a compare fires when the finished index is a multiple of `ckpt_period`. A period of 0 acts as 1.
- R8: With `ckpt_mode` = 2, a compare fires when the finished index equals list entry [pointer] and the pointer is below `list_len`. The pointer then advances by one. Once the pointer reaches `list_len`, no compare fires.
- R9: With `ckpt_mode` = 3, a compare fires when `ckpt_cond` is high in the finish cycle.
- R10: A decode match while an instruction is in flight (the finish cycle included) is ignored: the in-flight instruction's opcode and timing are unchanged. It also sets `overlap_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_match | input | NUM_OPS | Per-opcode decode match |
| commit | input | 1 | Commit pulse from the design under test |
| ckpt_cond | input | 1 | Condition for condition-mode checkpoints |
| ckpt_mode | input | 2 | 0 every, 1 periodic, 2 list, 3 condition |
| ckpt_period | input | PER_W | Period P for periodic mode |
| op_commit_mode | input | NUM_OPS | Per opcode: 1 commit-finished, 0 fixed latency |
| op_latency | input | NUM_OPS*LAT_W | Per-opcode fixed latency fields |
| list_wr_en | input | 1 | Write enable for the index list |
| list_wr_addr | input | LA_W | Index list write address |
| list_wr_data | input | IDX_W | Index list write data |
| list_len | input | LA_W+1 | Number of valid list entries |
| cmp_req | output | 1 | One-cycle compare request |
| cmp_index | output | IDX_W | Index of last finished instruction |
| cmp_opcode | output | OP_W | Opcode of last finished instruction |
| overlap_err | output | 1 | Sticky overlapping-decode flag |

## Verification
Call the start cycle S. A fixed-latency instruction finishes in cycle S+n, and a commit-finished one finishes in the cycle of its first qualifying commit. `cmp_req`, `cmp_index` and `cmp_opcode` are registered, so they become visible one cycle after the finish cycle. `overlap_err` becomes visible one cycle after the stray decode. The bench drives and samples on the falling edge and counts cycles from S. It checks that `cmp_req` stays low in cycles S+1 to S+n and then checks the strobe, index and opcode in cycle S+n+1. Checkpoint decisions come from a bench model that keeps its own index, period phase and list pointer. This model is evaluated with the condition value that was driven in the finish cycle.

// File: rtl/insn_ckpt_pkg.sv
package insn_ckpt_pkg;

    typedef enum logic [1:0] {
        CK_EVERY  = 2'd0,
        CK_PERIOD = 2'd1,
        CK_LIST   = 2'd2,
        CK_COND   = 2'd3
    } ck_mode_e;

    typedef enum logic [1:0] {
        TR_IDLE  = 2'd0,
        TR_COUNT = 2'd1,
        TR_AWAIT = 2'd2
    } tr_state_e;

endpackage

// File: rtl/insn_tracker.sv
module insn_tracker
    import insn_ckpt_pkg::*;
#(
    parameter int NUM_OPS = 4,
    parameter int LAT_W   = 4,
    parameter int OP_W    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_OPS-1:0]       dec_match,
    input  logic                     commit_i,
    input  logic [NUM_OPS-1:0]       op_commit_i,
    input  logic [NUM_OPS*LAT_W-1:0] op_lat_i,
    output logic                     fin_o,
    output logic [OP_W-1:0]          fin_op_o,
    output logic                     overlap_o
);

    tr_state_e         state_q, state_nx;
    logic [LAT_W-1:0]  cnt_q;
    logic [OP_W-1:0]   op_q;
    logic              overlap_q;

    logic [LAT_W-1:0]  lat_arr [NUM_OPS];
    logic [OP_W-1:0]   pick;
    logic              any_dec;
    logic [LAT_W-1:0]  load_val;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_lat
        assign lat_arr[g] = op_lat_i[g*LAT_W +: LAT_W];
    end

    always_comb begin
        pick = '0;
        for (int i = NUM_OPS - 1; i >= 0; i--) begin
            if (dec_match[i]) pick = OP_W'(i);
        end
    end

    assign any_dec  = |dec_match;
    assign load_val = (lat_arr[pick] == '0) ? '0 : lat_arr[pick] - 1'b1;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            TR_IDLE: begin
                if (any_dec) state_nx = op_commit_i[pick] ? TR_AWAIT : TR_COUNT;
            end
            TR_COUNT: begin
                if (cnt_q == '0) state_nx = TR_IDLE;
            end
            TR_AWAIT: begin
                if (commit_i) state_nx = TR_IDLE;
            end
            default: state_nx = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TR_IDLE;
        else     state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            op_q      <= '0;
            overlap_q <= 1'b0;
        end else begin
            if (state_q == TR_IDLE && any_dec) begin
                op_q  <= pick;
                cnt_q <= load_val;
            end else if (state_q == TR_COUNT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (state_q != TR_IDLE && any_dec) overlap_q <= 1'b1;
        end
    end

    always_comb begin
        fin_o     = ((state_q == TR_COUNT) && (cnt_q == '0)) ||
                    ((state_q == TR_AWAIT) && commit_i);
        fin_op_o  = op_q;
        overlap_o = overlap_q;
    end

    // R3: a running latency counter keeps the instruction in flight and steps down
    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == TR_COUNT && cnt_q != '0) |=> (state_q == TR_COUNT && cnt_q == $past(cnt_q) - 1'b1));

    // R4: without a commit the instruction keeps waiting
    p_await_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == TR_AWAIT && !commit_i) |=> (state_q == TR_AWAIT));

    // R10: the error flag never drops before reset
    p_overlap_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overlap_q |=> overlap_q);

    // R10: the opcode of an instruction in flight is not replaced
    p_busy_op_kept_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q != TR_IDLE) |=> (state_q == TR_IDLE || op_q == $past(op_q)));

endmodule

// File: rtl/ckpt_list.sv
module ckpt_list #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 16,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [IDX_W-1:0] wr_data,
    input  logic [AW:0]      len_i,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic             adv_i,
    output logic             hit_o
);

    logic [IDX_W-1:0] mem [DEPTH];
    logic [AW:0]      ptr_q;
    logic [AW:0]      len_eff;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign len_eff = (len_i > (AW+1)'(DEPTH)) ? (AW+1)'(DEPTH) : len_i;

    always_comb begin
        hit_o = (ptr_q < len_eff) && (mem[ptr_q[AW-1:0]] == probe_idx);
    end

    always_ff @(posedge clk) begin
        if (rst)                 ptr_q <= '0;
        else if (adv_i && hit_o) ptr_q <= ptr_q + 1'b1;
    end

    // R8: the pointer never runs past the storage
    p_ptr_bound_r8: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= (AW+1)'(DEPTH));

    // R8: the pointer moves by at most one entry per cycle
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/ckpt_gate.sv
module ckpt_gate
    import insn_ckpt_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int PER_W = 8,
    parameter int OP_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fin_i,
    input  logic [OP_W-1:0]  fin_op_i,
    input  ck_mode_e         mode_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             cond_i,
    input  logic             list_hit_i,
    output logic [IDX_W-1:0] next_idx_o,
    output logic             cmp_req_o,
    output logic [IDX_W-1:0] cmp_idx_o,
    output logic [OP_W-1:0]  cmp_op_o
);

    logic [IDX_W-1:0] done_q;
    logic [PER_W-1:0] phase_q;
    logic [PER_W-1:0] per_eff;
    logic             period_hit;
    logic             sel;
    logic             cmp_req_q;
    logic [IDX_W-1:0] cmp_idx_q;
    logic [OP_W-1:0]  cmp_op_q;

    assign per_eff    = (period_i == '0) ? PER_W'(1) : period_i;
    assign period_hit = (phase_q >= per_eff - 1'b1);
    assign next_idx_o = done_q + 1'b1;

    always_comb begin
        sel = 1'b0;
        unique case (mode_i)
            CK_EVERY:  sel = 1'b1;
            CK_PERIOD: sel = period_hit;
            CK_LIST:   sel = list_hit_i;
            CK_COND:   sel = cond_i;
            default:   sel = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= '0;
            phase_q   <= '0;
            cmp_req_q <= 1'b0;
            cmp_idx_q <= '0;
            cmp_op_q  <= '0;
        end else begin
            cmp_req_q <= fin_i && sel;
            if (fin_i) begin
                done_q    <= done_q + 1'b1;
                phase_q   <= period_hit ? '0 : phase_q + 1'b1;
                cmp_idx_q <= done_q + 1'b1;
                cmp_op_q  <= fin_op_i;
            end
        end
    end

    always_comb begin
        cmp_req_o = cmp_req_q;
        cmp_idx_o = cmp_idx_q;
        cmp_op_o  = cmp_op_q;
    end

    // R5: the request never lasts two cycles, as a finish is always followed by an idle cycle
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        cmp_req_q |=> !cmp_req_q);

    // R5: each finish advances the reported index by one
    p_index_step_r5: assert property (@(posedge clk) disable iff (rst)
        fin_i |=> (cmp_idx_q == $past(cmp_idx_q) + 1'b1));

    // R6: per-instruction mode requests a compare at every finish
    p_every_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (fin_i && mode_i == CK_EVERY) |=> cmp_req_q);

    // R9: condition mode never fires with the condition low
    p_cond_low_r9: assert property (@(posedge clk) disable iff (rst)
        (fin_i && mode_i == CK_COND && !cond_i) |=> !cmp_req_q);

endmodule

// File: rtl/insn_ckpt_monitor.sv
module insn_ckpt_monitor
    import insn_ckpt_pkg::*;
#(
    parameter int  NUM_OPS    = 4,
    parameter int  LAT_W      = 4,
    parameter int  IDX_W      = 16,
    parameter int  PER_W      = 8,
    parameter int  LIST_DEPTH = 16,
    localparam int OP_W       = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
    localparam int LA_W       = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_OPS-1:0]       dec_match,
    input  logic                     commit,
    input  logic                     ckpt_cond,
    input  logic [1:0]               ckpt_mode,
    input  logic [PER_W-1:0]         ckpt_period,
    input  logic [NUM_OPS-1:0]       op_commit_mode,
    input  logic [NUM_OPS*LAT_W-1:0] op_latency,
    input  logic                     list_wr_en,
    input  logic [LA_W-1:0]          list_wr_addr,
    input  logic [IDX_W-1:0]         list_wr_data,
    input  logic [LA_W:0]            list_len,
    output logic                     cmp_req,
    output logic [IDX_W-1:0]         cmp_index,
    output logic [OP_W-1:0]          cmp_opcode,
    output logic                     overlap_err
);

    ck_mode_e         mode;
    logic             fin;
    logic [OP_W-1:0]  fin_op;
    logic [IDX_W-1:0] next_idx;
    logic             list_hit;
    logic             list_adv;

    assign mode     = ck_mode_e'(ckpt_mode);
    assign list_adv = fin && (mode == CK_LIST);

    insn_tracker #(
        .NUM_OPS (NUM_OPS),
        .LAT_W   (LAT_W),
        .OP_W    (OP_W)
    ) i_tracker (
        .clk         (clk),
        .rst         (rst),
        .dec_match   (dec_match),
        .commit_i    (commit),
        .op_commit_i (op_commit_mode),
        .op_lat_i    (op_latency),
        .fin_o       (fin),
        .fin_op_o    (fin_op),
        .overlap_o   (overlap_err)
    );

    ckpt_list #(
        .DEPTH (LIST_DEPTH),
        .IDX_W (IDX_W),
        .AW    (LA_W)
    ) i_list (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (list_wr_en),
        .wr_addr   (list_wr_addr),
        .wr_data   (list_wr_data),
        .len_i     (list_len),
        .probe_idx (next_idx),
        .adv_i     (list_adv),
        .hit_o     (list_hit)
    );

    ckpt_gate #(
        .IDX_W (IDX_W),
        .PER_W (PER_W),
        .OP_W  (OP_W)
    ) i_gate (
        .clk        (clk),
        .rst        (rst),
        .fin_i      (fin),
        .fin_op_i   (fin_op),
        .mode_i     (mode),
        .period_i   (ckpt_period),
        .cond_i     (ckpt_cond),
        .list_hit_i (list_hit),
        .next_idx_o (next_idx),
        .cmp_req_o  (cmp_req),
        .cmp_idx_o  (cmp_index),
        .cmp_op_o   (cmp_opcode)
    );

endmodule

// File: tb/test_insn_ckpt_monitor.sv
module test_insn_ckpt_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  dec_match = '0;
    logic        commit = 1'b0;
    logic        ckpt_cond = 1'b0;
    logic [1:0]  ckpt_mode = '0;
    logic [7:0]  ckpt_period = '0;
    logic [3:0]  op_commit_mode = '0;
    logic [15:0] op_latency = '0;
    logic        list_wr_en = 1'b0;
    logic [3:0]  list_wr_addr = '0;
    logic [15:0] list_wr_data = '0;
    logic [4:0]  list_len = '0;
    logic        cmp_req;
    logic [15:0] cmp_index;
    logic [1:0]  cmp_opcode;
    logic        overlap_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_done;
    int m_ptr;
    int m_list [16];
    int m_len;
    int m_period;
    int m_mode;
    bit m_ovl;
    int m_lat [4];
    bit m_commit [4];

    always #10ns clk = ~clk;

    insn_ckpt_monitor i_insn_ckpt_monitor (
        .clk            (clk),
        .rst            (rst),
        .dec_match      (dec_match),
        .commit         (commit),
        .ckpt_cond      (ckpt_cond),
        .ckpt_mode      (ckpt_mode),
        .ckpt_period    (ckpt_period),
        .op_commit_mode (op_commit_mode),
        .op_latency     (op_latency),
        .list_wr_en     (list_wr_en),
        .list_wr_addr   (list_wr_addr),
        .list_wr_data   (list_wr_data),
        .list_len       (list_len),
        .cmp_req        (cmp_req),
        .cmp_index      (cmp_index),
        .cmp_opcode     (cmp_opcode),
        .overlap_err    (overlap_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_fire(input int idx, input bit cv);
        int p;
        p = (m_period == 0) ? 1 : m_period;
        case (m_mode)
            0: return 1'b1;
            1: return (idx % p) == 0;
            2: return (m_ptr < m_len) && (m_list[m_ptr] == idx);
            default: return cv;
        endcase
    endfunction

    task automatic do_reset(input int mode, input int period);
        @(negedge clk);
        rst = 1'b1;
        dec_match = '0;
        commit = 1'b0;
        m_mode = mode;
        m_period = period;
        ckpt_mode = 2'(mode);
        ckpt_period = 8'(period);
        for (int j = 0; j < 4; j++) begin
            op_latency[j*4 +: 4] = 4'(m_lat[j]);
            op_commit_mode[j] = m_commit[j];
        end
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_done = 0;
        m_ptr = 0;
        m_ovl = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        chk(cmp_req == 1'b0, "R1 cmp_req", int'(cmp_req), 0);
        chk(overlap_err == 1'b0, "R1 overlap_err", int'(overlap_err), 0);
        chk(cmp_index == 16'd0, "R1 cmp_index", int'(cmp_index), 0);
    endtask

    task automatic load_list(input int n, input int vals [16]);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            list_wr_en = 1'b1;
            list_wr_addr = 4'(k);
            list_wr_data = 16'(vals[k]);
            m_list[k] = vals[k];
        end
        @(negedge clk);
        list_wr_en = 1'b0;
        list_len = 5'(n);
        m_len = n;
    endtask

    // mask must have op as its lowest set bit; d is the commit delay for commit-finished opcodes
    task automatic run_insn(input int op, input logic [3:0] mask, input int d,
                            input bit early, input int inj);
        int  n;
        bit  cv;
        bit  fire;
        int  idx;
        string tag;
        n = m_commit[op] ? d : ((m_lat[op] == 0) ? 1 : m_lat[op]);
        tag = m_commit[op] ? "R4" : "R3";
        cv = 1'b0;
        dec_match = mask;
        commit = early && m_commit[op];
        ckpt_cond = 1'($urandom % 2);
        for (int c = 1; c <= n + 1; c++) begin
            @(negedge clk);
            if (c <= n) chk(cmp_req == 1'b0, {tag, " early strobe"}, int'(cmp_req), 0);
            if (c == inj && inj <= n) begin
                dec_match = 4'hF;
                m_ovl = 1'b1;
            end else begin
                dec_match = '0;
            end
            commit = m_commit[op] && (c == d);
            ckpt_cond = 1'($urandom % 2);
            if (c == n) cv = ckpt_cond;
        end
        idx = m_done + 1;
        fire = exp_fire(idx, cv);
        if (m_mode == 2 && fire) m_ptr++;
        m_done = idx;
        case (m_mode)
            0: chk(cmp_req == fire, "R6 strobe", int'(cmp_req), int'(fire));
            1: chk(cmp_req == fire, "R7 strobe", int'(cmp_req), int'(fire));
            2: chk(cmp_req == fire, "R8 strobe", int'(cmp_req), int'(fire));
            default: chk(cmp_req == fire, "R9 strobe", int'(cmp_req), int'(fire));
        endcase
        chk(cmp_index == 16'(idx), "R5 index", int'(cmp_index), idx);
        chk(cmp_opcode == 2'(op), "R2 opcode", int'(cmp_opcode), op);
        chk(overlap_err == m_ovl, "R10 overlap", int'(overlap_err), int'(m_ovl));
    endtask

    task automatic rand_insn(input int inj_pct);
        int op;
        logic [3:0] mask;
        int d;
        int inj;
        op = int'($urandom % 4);
        mask = (4'($urandom) & ~((4'b1 << op) - 4'b1)) | (4'b1 << op);
        d = 1 + int'($urandom % 4);
        inj = (int'($urandom % 100) < inj_pct) ? 1 + int'($urandom % 2) : 99;
        if (!m_commit[op] && inj > ((m_lat[op] == 0) ? 1 : m_lat[op])) inj = 99;
        if (m_commit[op] && inj > d) inj = 99;
        run_insn(op, mask, d, 1'($urandom % 2), inj);
    endtask

    initial begin
        int vals [16];
        void'($urandom(32'd5150));
        m_lat[0] = 1; m_commit[0] = 1'b0;
        m_lat[1] = 3; m_commit[1] = 1'b0;
        m_lat[2] = 0; m_commit[2] = 1'b1;
        m_lat[3] = 0; m_commit[3] = 1'b0;
        m_len = 0;
        for (int k = 0; k < 16; k++) vals[k] = 0;

        // per-instruction mode, directed corners first
        do_reset(0, 0);
        run_insn(0, 4'b0001, 1, 1'b0, 99);   // R3 single-cycle opcode, first index is 1 (R1)
        run_insn(3, 4'b1000, 1, 1'b0, 99);   // R3 latency field 0 acts as 1
        run_insn(2, 4'b0100, 2, 1'b1, 99);   // R4 commit in start cycle ignored
        run_insn(1, 4'b1010, 1, 1'b0, 99);   // R2 lowest set bit wins
        run_insn(1, 4'b0010, 1, 1'b0, 3);    // R10 stray decode in finish cycle
        for (int k = 0; k < 25; k++) rand_insn(0);

        // R1: reset clears the sticky flag; periodic mode
        do_reset(1, 3);
        for (int k = 0; k < 20; k++) rand_insn(15);

        // R7: period 0 behaves as 1
        do_reset(1, 0);
        for (int k = 0; k < 5; k++) rand_insn(0);

        // R8: index list mode, then exhaustion
        do_reset(2, 0);
        vals[0] = 2; vals[1] = 3; vals[2] = 7; vals[3] = 11;
        load_list(4, vals);
        for (int k = 0; k < 16; k++) rand_insn(10);

        // R8: after reset the pointer starts over at the first entry
        do_reset(2, 0);
        for (int k = 0; k < 4; k++) rand_insn(0);

        // R9: condition mode
        do_reset(3, 0);
        for (int k = 0; k < 20; k++) rand_insn(10);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule